// File: doc/BRIEF.md
# Spike Event Synaptic Row Engine

This block turns incoming spike events into per-synapse accumulate commands for a neuron array. Each event arrives as a packet holding an 8-bit control byte and a 32-bit routing key that names the neuron that fired. Only packets whose control byte marks them as multicast are processed. The other packets are taken off the input and discarded.

A multicast key is matched against a small table of routes fixed by parameters. A hit gives the start address and the length of the source neuron's synaptic row in an external weight memory. The block issues one burst read for that row and collects the words into a local row buffer. Once the last word has arrived, it walks the row in memory order and sends one (target index, weight) command per entry. Layers are fully connected, so entry i of a row always drives neuron i of the next layer. A key that matches no route is dropped and counted. Keys arriving while a row is being fetched or issued wait in a small queue.

Top module: `spk_event_engine`

## Requirements
- R1: After reset, pkt_ready is 1, rd_req_valid and acc_valid are 0, and miss_count is 0.
- R2: The packet type is control byte bits [7:6], and 2'b00 means multicast. Every other type is consumed without a memory request, without an accumulate command and without a change to miss_count.
- R3: Control byte bits [5:0], which carry the emergency-routing and timestamp information, have no effect on processing.
- R4: Route r hits when (key & MASK_r) == VALUE_r, and the lowest-numbered hitting route wins. The request address is BASE_r + (key & ~MASK_r) * LEN_r and the request length is LEN_r. The defaults are route 0 (value 0x1000, mask 0xFFFFFFF0, base 0x100, length 4), route 1 (0x2000, 0xFFFFFF00, 0x800, 6) and route 2 (0x1000, 0xFFFFFF00, 0x4000, 3).
- R5: A multicast key that hits no route makes no request, and miss_count rises by exactly 1.
- R6: No accumulate command is offered until all LEN response words of the row have been received. Gaps between response words are allowed.
- R7: Row entries are issued strictly in memory order. Entry i carries target index i and weight equal to response word bits [21:0] (Q6.16). The delay bit [22] and bits [31:23] are ignored.
- R8: While acc_ready is high, one entry is issued per cycle. While acc_valid is high and acc_ready is low, the target and weight hold steady.
- R9: Multicast packets queue in a FIFO of FIFO_DEPTH entries (default 4) while the engine is busy. pkt_ready is low exactly when the queue is full, and queued keys are served in arrival order.
- R10: At most one memory request is outstanding, one per hitting key. Its address and length hold steady until rd_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet accepted this cycle when high with pkt_valid |
| pkt_ctrl | input | 8 | Control byte; type in bits [7:6] |
| pkt_key | input | 32 | Routing key of the firing neuron |
| rd_req_valid | output | 1 | Burst read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Word address of the first row word |
| rd_req_len | output | LEN_W | Number of words in the burst |
| rd_rsp_valid | input | 1 | Response word present |
| rd_rsp_data | input | WORD_W | Synaptic word: weight [21:0], delay [22] |
| acc_valid | output | 1 | Accumulate command offered |
| acc_ready | input | 1 | Neuron array takes the command |
| acc_target | output | IDX_W | Target neuron index within the next layer |
| acc_weight | output | WGT_W | Q6.16 weight to add |
| miss_count | output | MISS_W | Number of multicast keys that missed all routes |

## Verification
Two functions can fall in the same cycle here. New packets are enqueued while the engine is still issuing a row, and the issue path is stalled by the neuron array. Both are provoked together by holding acc_ready low while five multicast packets are offered. The test then checks that pkt_ready falls once four keys are queued and that the stalled command holds entry 0. After the stall is released, it checks that every queued key yields its full row, with correct weights, in arrival order. A second run toggles acc_ready every cycle, and each accepted entry is compared against the weight model held in the test.

// File: rtl/spk_pkg.sv
package spk_pkg;

    localparam int CTRL_W = 8;
    localparam int KEY_W  = 32;
    localparam int RLEN_W = 8;

    localparam logic [1:0] PKT_TYPE_MC = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_FETCH,
        ST_ISSUE
    } eng_state_e;

    function automatic logic is_multicast(input logic [CTRL_W-1:0] ctrl);
        return ctrl[CTRL_W-1 -: 2] == PKT_TYPE_MC;
    endfunction

endpackage

// File: rtl/spk_key_fifo.sv
module spk_key_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        if (push && !pop)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != CW'(DEPTH)) || pop);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0);

endmodule

// File: rtl/spk_route_lookup.sv
module spk_route_lookup
    import spk_pkg::*;
#(
    parameter int NUM_ROUTES = 3,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 5,
    parameter logic [NUM_ROUTES*KEY_W-1:0]  ROUTE_VALUE = '0,
    parameter logic [NUM_ROUTES*KEY_W-1:0]  ROUTE_MASK  = '0,
    parameter logic [NUM_ROUTES*KEY_W-1:0]  ROUTE_BASE  = '0,
    parameter logic [NUM_ROUTES*RLEN_W-1:0] ROUTE_LEN   = '0
) (
    input  logic [KEY_W-1:0]  key,
    output logic              hit,
    output logic [ADDR_W-1:0] row_addr,
    output logic [LEN_W-1:0]  row_len
);
    localparam int SEL_W = (NUM_ROUTES > 1) ? $clog2(NUM_ROUTES) : 1;

    logic [NUM_ROUTES-1:0] hit_vec;

    genvar r;
    generate
        for (r = 0; r < NUM_ROUTES; r++) begin : g_route
            assign hit_vec[r] =
                (key & ROUTE_MASK[r*KEY_W +: KEY_W]) == ROUTE_VALUE[r*KEY_W +: KEY_W];
        end
    endgenerate

    logic [SEL_W-1:0]  sel;
    logic [KEY_W-1:0]  offs;
    logic [KEY_W-1:0]  prod;
    logic [KEY_W-1:0]  base;
    logic [RLEN_W-1:0] len8;

    always_comb begin
        sel = '0;
        for (int i = NUM_ROUTES - 1; i >= 0; i--) begin
            if (hit_vec[i])
                sel = SEL_W'(i);
        end
        hit  = |hit_vec;
        offs = key & ~ROUTE_MASK[sel*KEY_W +: KEY_W];
        base = ROUTE_BASE[sel*KEY_W +: KEY_W];
        len8 = ROUTE_LEN[sel*RLEN_W +: RLEN_W];
        prod = offs * {{(KEY_W-RLEN_W){1'b0}}, len8};
        row_addr = ADDR_W'(base + prod);
        row_len  = LEN_W'(len8);
    end

endmodule

// File: rtl/spk_row_buf.sv
module spk_row_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
    } rowbuf_st_t;

    rowbuf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we)
            st_d.mem[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rdata = st_q.mem[AW'(idx)];

endmodule

// File: rtl/spk_event_engine.sv
module spk_event_engine
    import spk_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int MAX_ROW    = 16,
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int WGT_W      = 22,
    parameter int MISS_W     = 16,
    parameter int NUM_ROUTES = 3,
    parameter int LEN_W      = $clog2(MAX_ROW + 1),
    parameter int IDX_W      = $clog2(MAX_ROW),
    parameter logic [NUM_ROUTES*KEY_W-1:0]  ROUTE_VALUE =
        {32'h0000_1000, 32'h0000_2000, 32'h0000_1000},
    parameter logic [NUM_ROUTES*KEY_W-1:0]  ROUTE_MASK  =
        {32'hFFFF_FF00, 32'hFFFF_FF00, 32'hFFFF_FFF0},
    parameter logic [NUM_ROUTES*KEY_W-1:0]  ROUTE_BASE  =
        {32'h0000_4000, 32'h0000_0800, 32'h0000_0100},
    parameter logic [NUM_ROUTES*RLEN_W-1:0] ROUTE_LEN   =
        {8'd3, 8'd6, 8'd4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [7:0]        pkt_ctrl,
    input  logic [31:0]       pkt_key,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [LEN_W-1:0]  rd_req_len,
    input  logic              rd_rsp_valid,
    input  logic [WORD_W-1:0] rd_rsp_data,
    output logic              acc_valid,
    input  logic              acc_ready,
    output logic [IDX_W-1:0]  acc_target,
    output logic [WGT_W-1:0]  acc_weight,
    output logic [MISS_W-1:0] miss_count
);

    typedef struct packed {
        eng_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  idx;
        logic [MISS_W-1:0] miss;
    } eng_st_t;

    eng_st_t st_d, st_q;

    // input side: type filter feeding the key queue
    logic             fifo_full, fifo_empty, fifo_push, fifo_pop;
    logic [KEY_W-1:0] fifo_head;

    assign pkt_ready = !fifo_full;
    assign fifo_push = pkt_valid && pkt_ready && is_multicast(pkt_ctrl);

    spk_key_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (KEY_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (pkt_key),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    logic              lk_hit;
    logic [ADDR_W-1:0] lk_addr;
    logic [LEN_W-1:0]  lk_len;

    spk_route_lookup #(
        .NUM_ROUTES  (NUM_ROUTES),
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .ROUTE_VALUE (ROUTE_VALUE),
        .ROUTE_MASK  (ROUTE_MASK),
        .ROUTE_BASE  (ROUTE_BASE),
        .ROUTE_LEN   (ROUTE_LEN)
    ) u_lookup (
        .key      (fifo_head),
        .hit      (lk_hit),
        .row_addr (lk_addr),
        .row_len  (lk_len)
    );

    logic             buf_we;
    logic [WGT_W-1:0] buf_rdata;

    spk_row_buf #(
        .DEPTH (MAX_ROW),
        .W     (WGT_W)
    ) u_rowbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .idx   (st_q.idx),
        .wdata (rd_rsp_data[WGT_W-1:0]),
        .rdata (buf_rdata)
    );

    // delay bit, upper word bits and control flags other than the type are unused
    logic unused_bits;
    assign unused_bits = ^{pkt_ctrl[5:0], rd_rsp_data[WORD_W-1:WGT_W]};

    logic [IDX_W-1:0] last_idx;
    assign last_idx = IDX_W'(st_q.len - 1'b1);

    always_comb begin
        st_d         = st_q;
        fifo_pop     = 1'b0;
        buf_we       = 1'b0;
        rd_req_valid = 1'b0;
        acc_valid    = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    if (lk_hit) begin
                        st_d.addr  = lk_addr;
                        st_d.len   = lk_len;
                        st_d.state = ST_REQ;
                    end else begin
                        st_d.miss = st_q.miss + 1'b1;
                    end
                end
            end
            ST_REQ: begin
                rd_req_valid = 1'b1;
                if (rd_req_ready) begin
                    st_d.idx   = '0;
                    st_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_rsp_valid) begin
                    buf_we = 1'b1;
                    if (st_q.idx == last_idx) begin
                        st_d.idx   = '0;
                        st_d.state = ST_ISSUE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                acc_valid = 1'b1;
                if (acc_ready) begin
                    if (st_q.idx == last_idx) begin
                        st_d.idx   = '0;
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{state: ST_IDLE, default: '0};
        else
            st_q <= st_d;
    end

    assign rd_req_addr = st_q.addr;
    assign rd_req_len  = st_q.len;
    assign acc_target  = st_q.idx;
    assign acc_weight  = buf_rdata;
    assign miss_count  = st_q.miss;

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_ready |=> acc_valid && $stable(acc_target) && $stable(acc_weight));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));

    // R6
    no_issue_while_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_valid |-> !acc_valid && !rd_req_valid);

    // R5
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_count != $past(miss_count) |-> miss_count == $past(miss_count) + MISS_W'(1));

endmodule

// File: tb/spk_event_engine_test.sv
`timescale 1ns/100ps
module spk_event_engine_test;

    localparam int NV = 10;
    // fields: ctrl[95:88] key[87:56] len[55:48] addr[47:16] miss[15:0]
    localparam logic [95:0] VEC [NV] = '{
        {8'h00, 32'h0000_1005, 8'd4, 32'h0000_0114, 16'd0}, // R4 overlap, route 0 wins
        {8'h00, 32'h0000_2011, 8'd6, 32'h0000_0866, 16'd0}, // R4 route 1
        {8'h00, 32'h0000_1025, 8'd3, 32'h0000_406F, 16'd0}, // R4 route 2 only
        {8'h40, 32'h0000_1005, 8'd0, 32'h0,         16'd0}, // R2 non-multicast
        {8'h00, 32'h0000_3000, 8'd0, 32'h0,         16'd1}, // R5 miss
        {8'h3F, 32'h0000_100F, 8'd4, 32'h0000_013C, 16'd1}, // R3 low flags set
        {8'hC0, 32'h0000_7777, 8'd0, 32'h0,         16'd1}, // R2 other type, no miss
        {8'h00, 32'h0000_10FF, 8'd3, 32'h0000_42FD, 16'd1}, // R4
        {8'h00, 32'h0000_20FF, 8'd6, 32'h0000_0DFA, 16'd1}, // R4
        {8'h00, 32'hFFFF_1000, 8'd0, 32'h0,         16'd2}  // R5 upper bits
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        pkt_valid = 0;
    logic        pkt_ready;
    logic [7:0]  pkt_ctrl = 0;
    logic [31:0] pkt_key = 0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1;
    logic [31:0] rd_req_addr;
    logic [4:0]  rd_req_len;
    logic        rd_rsp_valid = 0;
    logic [31:0] rd_rsp_data = 0;
    logic        acc_valid;
    logic        acc_ready = 1;
    logic [3:0]  acc_target;
    logic [21:0] acc_weight;
    logic [15:0] miss_count;

    spk_event_engine uut (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_ctrl(pkt_ctrl), .pkt_key(pkt_key),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_target(acc_target), .acc_weight(acc_weight),
        .miss_count(miss_count)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    int req_seen = 0;
    int acc_seen = 0;
    int early_acc = 0;
    int acc_idx = 0;
    bit rsp_busy = 0;
    bit stall_mode = 0;
    bit hold_ready = 0;
    logic [31:0] exp_addr = 0;
    logic [7:0]  exp_len = 0;
    logic [31:0] cur_addr = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = a * 32'd613 + 32'd11;
        return {a[8:0], a[0], w[21:0]};
    endfunction

    function automatic logic [21:0] exp_weight(input logic [31:0] a);
        logic [31:0] w;
        w = a * 32'd613 + 32'd11;
        return w[21:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    task automatic send(input logic [7:0] c, input logic [31:0] k);
        @(negedge clk);
        pkt_valid = 1; pkt_ctrl = c; pkt_key = k;
        #1;
        while (!pkt_ready) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        pkt_valid = 0;
    endtask

    // memory model: accepts a request, streams the row with a gap after word 1
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rd_req_valid && rd_req_ready) begin
                logic [31:0] a;
                int n;
                a = rd_req_addr;
                n = int'(rd_req_len);
                req_seen++;
                cur_addr = a;
                acc_idx = 0;
                chk(a == exp_addr, "R4 request address", a, exp_addr);
                chk(n == int'(exp_len), "R4 request length", n, exp_len);
                rsp_busy = 1;
                @(negedge clk);
                @(negedge clk);
                for (int i = 0; i < n; i++) begin
                    rd_rsp_valid = 1;
                    rd_rsp_data = mem_word(a + 32'(i));
                    @(negedge clk);
                    if (i == 1) begin
                        rd_rsp_valid = 0;
                        @(negedge clk);
                    end
                end
                rd_rsp_valid = 0;
                rsp_busy = 0;
            end
        end
    end

    // accumulate-side ready pattern
    initial begin
        forever begin
            @(negedge clk);
            if (hold_ready) acc_ready = 0;
            else if (stall_mode) acc_ready = ~acc_ready;
            else acc_ready = 1;
        end
    end

    // accumulate monitor
    initial begin
        forever begin
            @(negedge clk); #1;
            if (acc_valid && rsp_busy) early_acc++;
            if (acc_valid && acc_ready) begin
                chk(acc_target == 4'(acc_idx), "R7 target order", acc_target, acc_idx);
                chk(acc_weight == exp_weight(cur_addr + 32'(acc_idx)), "R7 weight",
                    acc_weight, exp_weight(cur_addr + 32'(acc_idx)));
                acc_idx++;
                acc_seen++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(pkt_ready == 1, "R1 pkt_ready", pkt_ready, 1);
        chk(rd_req_valid == 0, "R1 rd_req_valid", rd_req_valid, 0);
        chk(acc_valid == 0, "R1 acc_valid", acc_valid, 0);
        chk(miss_count == 0, "R1 miss_count", miss_count, 0);
        @(negedge clk);
        rst_n = 1;

        for (int v = 0; v < NV; v++) begin
            logic [95:0] e;
            e = VEC[v];
            exp_addr = e[47:16];
            exp_len  = e[55:48];
            req_seen = 0;
            acc_seen = 0;
            send(e[95:88], e[87:56]);
            repeat (40) @(negedge clk);
            #1;
            chk(req_seen == (exp_len != 0 ? 1 : 0), "R10 R2 R5 request count",
                req_seen, (exp_len != 0 ? 1 : 0));
            chk(acc_seen == int'(exp_len), "R7 R3 entries issued", acc_seen, exp_len);
            chk(miss_count == e[15:0], "R5 miss_count", miss_count, e[15:0]);
        end

        // R8: toggling acc_ready, row of six
        stall_mode = 1;
        exp_addr = 32'h0000_0866; exp_len = 6;
        req_seen = 0; acc_seen = 0;
        send(8'h00, 32'h0000_2011);
        repeat (60) @(negedge clk);
        #1;
        chk(acc_seen == 6, "R8 entries under stall", acc_seen, 6);
        stall_mode = 0;

        // R9: queue fills while issue is blocked
        hold_ready = 1;
        exp_addr = 32'h0000_0114; exp_len = 4;
        req_seen = 0; acc_seen = 0;
        for (int p = 0; p < 5; p++) send(8'h00, 32'h0000_1005);
        repeat (20) @(negedge clk);
        #1;
        chk(pkt_ready == 0, "R9 pkt_ready when full", pkt_ready, 0);
        chk(acc_valid == 1 && acc_target == 0, "R8 stalled entry held", acc_target, 0);
        chk(acc_seen == 0, "R8 nothing taken while blocked", acc_seen, 0);
        hold_ready = 0;
        repeat (120) @(negedge clk);
        #1;
        chk(req_seen == 5, "R9 all queued keys served", req_seen, 5);
        chk(acc_seen == 20, "R9 all queued rows issued", acc_seen, 20);
        chk(pkt_ready == 1, "R9 pkt_ready after drain", pkt_ready, 1);
        chk(miss_count == 16'd2, "R5 miss_count unchanged", miss_count, 2);
        chk(early_acc == 0, "R6 no entry before row complete", early_acc, 0);

        summary();
        $finish;
    end

endmodule